// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits beside a double-data-rate SDRAM command bus and watches every command the controller drives. It decodes chip select, row strobe, column strobe, write enable, the bank address, address bit 10 and clock enable into a command code. From that it keeps an open or closed state for each bank. Elapsed-cycle counters, some per bank and some shared across banks, measure the spacing between related commands.

A command that breaks a state rule or comes too early is reported through a sticky violation flag. The flag carries a reason code and the bank involved. A command that breaks a state rule is treated as never issued and leaves the tracking untouched. A command that only breaks a spacing rule is assumed to have taken effect. The guard issues nothing itself and is meant for simulation monitors, emulation and silicon debug.

Top module: `sdram_cmd_guard`

## Requirements
- R1: `cmd_code` shows the command sampled at the previous rising edge. The codes are: 0 deselect (chip select high), 1 no-op, 2 burst stop, 3 read, 4 write, 5 activate, 6 precharge one bank, 7 precharge all (address bit 10 high), 8 auto refresh, 9 mode-register set, 10 clock suspended. Code 10 applies whenever clock enable is low now or was low in the previous cycle. Reset gives 0.
- R2: `bank_open` bit b is set by a legal activate to bank b and cleared by a precharge to bank b or by precharge-all. A precharge to a closed bank does nothing. Reset clears all bits.
- R3: An activate to an open bank raises reason 1, and a read or write to a closed bank raises reason 2. Neither command changes the bank state or any counter.
- R4: An auto refresh or mode-register set issued while any bank is open raises reason 3, reported against the lowest open bank, and the command is otherwise ignored.
- R5: If clock enable falls while any bank is open, reason 4 is raised, reported against the lowest open bank.
- R6: Same-bank spacing, counted in cycles after the earlier command. Activate to read or write needs at least tRCD (reason 5). Precharge to activate needs at least tRP (reason 6). Activate to precharge needs at least tRAS (reason 7). Activate to activate needs at least tRC (reason 8).
- R7: An activate fewer than tRRD cycles after an activate to any bank raises reason 9.
- R8: Any command other than deselect or no-op raises reason 10 if it comes fewer than tRFC cycles after a refresh. It raises reason 13 if it comes fewer than tMRD cycles after a mode-register set.
- R9: A precharge less than tWR cycles after a write to that bank raises reason 11. A read less than tWTR cycles after any write raises reason 12.
- R10: A bank that stays open for more than the tRAS maximum, in cycles, raises reason 14.
- R11: The first violation sets `viol` and latches `viol_reason` and `viol_bank`. These hold until `viol_clr`, which returns all three to zero. If several rules fail in one cycle, the lowest reason wins. If `viol_clr` and a new violation coincide, the new one is latched.
- R12: Each nanosecond limit becomes ceil(limit / clock period) cycles. With the default 5 ns clock, the limits are tRCD 3, tRP 3, tRAS 8, tRC 11, tRRD 2, tRFC 14, tWR 3 and tRAS maximum 24000. tWTR and tMRD are 2 cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank precharge select) |
| cke | input | 1 | Clock enable |
| viol_clr | input | 1 | Clears the sticky violation record |
| cmd_code | output | 4 | Registered decoded command |
| bank_open | output | 2**BA_W | Per-bank open state |
| viol | output | 1 | Sticky violation flag |
| viol_reason | output | 4 | Reason code of the latched violation |
| viol_bank | output | BA_W | Bank of the latched violation |

## Verification
The assertions assume that every input is a known level at each rising edge and that `viol_clr` is a plain level that can coincide with any command. They also assume that clock enable may drop in any cycle, so that a falling edge of clock enable with banks open is a real event and not noise. The stimulus drives all pins only on the falling clock edge and draws every command, bank, bit 10 value, clock enable dip and clear from fixed-seed random numbers over legal pin levels. It mixes in directed sequences that sit exactly on the spacing limits and on the tRAS maximum.

// File: rtl/sdram_cmd_guard_pkg.sv
package sdram_cmd_guard_pkg;

  typedef enum logic [3:0] {
    CMD_DESL = 4'd0,
    CMD_NOP  = 4'd1,
    CMD_BST  = 4'd2,
    CMD_RD   = 4'd3,
    CMD_WR   = 4'd4,
    CMD_ACT  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_PALL = 4'd7,
    CMD_REF  = 4'd8,
    CMD_MRS  = 4'd9,
    CMD_SUSP = 4'd10
  } cmd_e;

  localparam logic [3:0] RSN_ACT_OPEN  = 4'd1;
  localparam logic [3:0] RSN_RW_CLOSED = 4'd2;
  localparam logic [3:0] RSN_BUSY      = 4'd3;
  localparam logic [3:0] RSN_CKE_BUSY  = 4'd4;

  // Round a time in picoseconds up to whole clock cycles.
  function automatic int unsigned ns_cycles(int unsigned t_ps, int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/cmdg_decode.sv
module cmdg_decode
  import sdram_cmd_guard_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  input  logic cke,
  input  logic cke_q,
  output cmd_e cmd
);

  always_comb begin
    if (!cke || !cke_q) begin
      cmd = CMD_SUSP;
    end else if (cs_n) begin
      cmd = CMD_DESL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_BST;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = a10 ? CMD_PALL : CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/cmdg_elapsed.sv
// Cycles since the last load: 1 in the cycle after a load, then counting up to CAP and holding.
module cmdg_elapsed #(
  parameter int unsigned W   = 8,
  parameter int unsigned CAP = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CAPV = W'(CAP);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= CAPV;
    else if (load)         cnt <= W'(1);
    else if (cnt != CAPV)  cnt <= cnt + W'(1);
  end

  assert_elapsed_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == W'(1));

  assert_elapsed_nonzero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_cmd_guard_pkg::*;
#(
  parameter int unsigned BA_W         = 2,
  parameter int unsigned CLK_PS       = 5000,
  parameter int unsigned T_RCD_PS     = 15000,
  parameter int unsigned T_RP_PS      = 15000,
  parameter int unsigned T_RAS_PS     = 40000,
  parameter int unsigned T_RAS_MAX_PS = 120000000,
  parameter int unsigned T_RC_PS      = 55000,
  parameter int unsigned T_RRD_PS     = 10000,
  parameter int unsigned T_RFC_PS     = 70000,
  parameter int unsigned T_WR_PS      = 15000,
  parameter int unsigned T_WTR_CK     = 2,
  parameter int unsigned T_MRD_CK     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic              a10,
  input  logic              cke,
  input  logic              viol_clr,
  output logic [3:0]        cmd_code,
  output logic [(1<<BA_W)-1:0] bank_open,
  output logic              viol,
  output logic [3:0]        viol_reason,
  output logic [BA_W-1:0]   viol_bank
);

  localparam int unsigned NB       = 1 << BA_W;
  localparam int unsigned N_RASMAX = ns_cycles(T_RAS_MAX_PS, CLK_PS);
  localparam int unsigned CAP      = N_RASMAX + 1;
  localparam int unsigned CW       = $clog2(CAP + 1);

  localparam logic [CW-1:0] L_RCD    = CW'(ns_cycles(T_RCD_PS, CLK_PS));
  localparam logic [CW-1:0] L_RP     = CW'(ns_cycles(T_RP_PS,  CLK_PS));
  localparam logic [CW-1:0] L_RAS    = CW'(ns_cycles(T_RAS_PS, CLK_PS));
  localparam logic [CW-1:0] L_RC     = CW'(ns_cycles(T_RC_PS,  CLK_PS));
  localparam logic [CW-1:0] L_RRD    = CW'(ns_cycles(T_RRD_PS, CLK_PS));
  localparam logic [CW-1:0] L_RFC    = CW'(ns_cycles(T_RFC_PS, CLK_PS));
  localparam logic [CW-1:0] L_WR     = CW'(ns_cycles(T_WR_PS,  CLK_PS));
  localparam logic [CW-1:0] L_WTR    = CW'(T_WTR_CK);
  localparam logic [CW-1:0] L_MRD    = CW'(T_MRD_CK);
  localparam logic [CW-1:0] L_RASMAX = CW'(N_RASMAX);

  function automatic logic [BA_W-1:0] first_bank(logic [NB-1:0] m);
    first_bank = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (m[i]) first_bank = BA_W'(i);
    end
  endfunction

  logic          cke_q;
  cmd_e          cmd, cmd_q;
  logic [NB-1:0] open_q, sel, pre_mask, ld_act, ld_wr;
  logic [NB-1:0] ras_fail, twr_fail, old_fail;
  logic [CW-1:0] act_cnt [NB];
  logic [CW-1:0] pre_cnt [NB];
  logic [CW-1:0] wr_cnt  [NB];
  logic [CW-1:0] g_act_cnt, g_ref_cnt, g_mrs_cnt, g_wr_cnt;
  logic          is_real, any_open, tgt_open;
  logic          act_ok, rd_ok, wr_ok, ref_ok, mrs_ok;
  logic [15:0]   hit;
  logic [BA_W-1:0] hit_bank [16];
  logic [3:0]    pick;
  logic [BA_W-1:0] pick_bank;

  cmdg_decode u_decode (
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .a10 (a10), .cke (cke), .cke_q (cke_q), .cmd (cmd)
  );

  assign sel      = NB'(1) << ba;
  assign any_open = |open_q;
  assign tgt_open = |(open_q & sel);
  assign is_real  = cmd inside {CMD_BST, CMD_RD, CMD_WR, CMD_ACT, CMD_PRE,
                                CMD_PALL, CMD_REF, CMD_MRS};
  assign act_ok   = (cmd == CMD_ACT) && !tgt_open;
  assign rd_ok    = (cmd == CMD_RD)  &&  tgt_open;
  assign wr_ok    = (cmd == CMD_WR)  &&  tgt_open;
  assign ref_ok   = (cmd == CMD_REF) && !any_open;
  assign mrs_ok   = (cmd == CMD_MRS) && !any_open;
  assign pre_mask = open_q & ((cmd == CMD_PALL) ? {NB{1'b1}} :
                              (cmd == CMD_PRE)  ? sel : {NB{1'b0}});
  assign ld_act   = act_ok ? sel : '0;
  assign ld_wr    = wr_ok  ? sel : '0;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    cmdg_elapsed #(.W(CW), .CAP(CAP)) u_act (
      .clk (clk), .rst_n (rst_n), .load (ld_act[b]),   .cnt (act_cnt[b]));
    cmdg_elapsed #(.W(CW), .CAP(CAP)) u_pre (
      .clk (clk), .rst_n (rst_n), .load (pre_mask[b]), .cnt (pre_cnt[b]));
    cmdg_elapsed #(.W(CW), .CAP(CAP)) u_wr (
      .clk (clk), .rst_n (rst_n), .load (ld_wr[b]),    .cnt (wr_cnt[b]));
    assign ras_fail[b] = pre_mask[b] && (act_cnt[b] < L_RAS);
    assign twr_fail[b] = pre_mask[b] && (wr_cnt[b]  < L_WR);
    assign old_fail[b] = open_q[b]   && (act_cnt[b] > L_RASMAX);
  end

  cmdg_elapsed #(.W(CW), .CAP(CAP)) u_g_act (
    .clk (clk), .rst_n (rst_n), .load (act_ok), .cnt (g_act_cnt));
  cmdg_elapsed #(.W(CW), .CAP(CAP)) u_g_ref (
    .clk (clk), .rst_n (rst_n), .load (ref_ok), .cnt (g_ref_cnt));
  cmdg_elapsed #(.W(CW), .CAP(CAP)) u_g_mrs (
    .clk (clk), .rst_n (rst_n), .load (mrs_ok), .cnt (g_mrs_cnt));
  cmdg_elapsed #(.W(CW), .CAP(CAP)) u_g_wr (
    .clk (clk), .rst_n (rst_n), .load (wr_ok),  .cnt (g_wr_cnt));

  // One hit bit per reason code; the lowest code set wins.
  always_comb begin
    hit = '0;
    for (int r = 0; r < 16; r++) hit_bank[r] = ba;
    hit[1]  = (cmd == CMD_ACT) && tgt_open;
    hit[2]  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && !tgt_open;
    hit[3]  = ((cmd == CMD_REF) || (cmd == CMD_MRS)) && any_open;
    hit[4]  = cke_q && !cke && any_open;
    hit[5]  = (rd_ok || wr_ok) && (act_cnt[ba] < L_RCD);
    hit[6]  = act_ok && (pre_cnt[ba] < L_RP);
    hit[7]  = |ras_fail;
    hit[8]  = act_ok && (act_cnt[ba] < L_RC);
    hit[9]  = act_ok && (g_act_cnt < L_RRD);
    hit[10] = is_real && (g_ref_cnt < L_RFC);
    hit[11] = |twr_fail;
    hit[12] = rd_ok && (g_wr_cnt < L_WTR);
    hit[13] = is_real && (g_mrs_cnt < L_MRD);
    hit[14] = |old_fail;
    hit_bank[3]  = first_bank(open_q);
    hit_bank[4]  = first_bank(open_q);
    hit_bank[7]  = first_bank(ras_fail);
    hit_bank[11] = first_bank(twr_fail);
    hit_bank[14] = first_bank(old_fail);
    pick      = '0;
    pick_bank = '0;
    for (int r = 15; r >= 0; r--) begin
      if (hit[r]) begin
        pick      = 4'(r);
        pick_bank = hit_bank[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q       <= 1'b1;
      open_q      <= '0;
      cmd_q       <= CMD_DESL;
      viol        <= 1'b0;
      viol_reason <= '0;
      viol_bank   <= '0;
    end else begin
      cke_q  <= cke;
      open_q <= (open_q & ~pre_mask) | ld_act;
      cmd_q  <= cmd;
      if ((pick != '0) && (!viol || viol_clr)) begin
        viol        <= 1'b1;
        viol_reason <= pick;
        viol_bank   <= pick_bank;
      end else if (viol_clr) begin
        viol        <= 1'b0;
        viol_reason <= '0;
        viol_bank   <= '0;
      end
    end
  end

  assign cmd_code  = cmd_q;
  assign bank_open = open_q;

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_ok |=> (open_q & $past(sel)) != '0);

  assert_pall_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PALL) |=> open_q == '0);

  assert_busy_refresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((cmd == CMD_REF) || (cmd == CMD_MRS)) && any_open && !viol)
      |=> (viol && viol_reason == RSN_BUSY));

  assert_cke_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && !cke && any_open && !viol) |=> (viol && viol_reason == RSN_CKE_BUSY));

  assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !viol_clr) |=> (viol && $stable(viol_reason) && $stable(viol_bank)));

endmodule

// File: tb/test_sdram_cmd_guard.sv
module test_sdram_cmd_guard;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int TCK    = 10;
  localparam int NOM_PS = 5000;

  function automatic int cyc(int t_ns);
    return (t_ns * 1000 + NOM_PS - 1) / NOM_PS;
  endfunction

  localparam int Q_RCD    = cyc(15);
  localparam int Q_RP     = cyc(15);
  localparam int Q_RAS    = cyc(40);
  localparam int Q_RC     = cyc(55);
  localparam int Q_RRD    = cyc(10);
  localparam int Q_RFC    = cyc(70);
  localparam int Q_WR     = cyc(15);
  localparam int Q_RASMAX = cyc(120000);
  localparam int BIG      = 1000000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic a10 = 1'b0, cke = 1'b1, viol_clr = 1'b0;
  logic [3:0] cmd_code;
  logic [3:0] bank_open;
  logic viol;
  logic [3:0] viol_reason;
  logic [1:0] viol_bank;

  sdram_cmd_guard i_sdram_cmd_guard (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .ba (ba), .a10 (a10), .cke (cke), .viol_clr (viol_clr),
    .cmd_code (cmd_code), .bank_open (bank_open), .viol (viol),
    .viol_reason (viol_reason), .viol_bank (viol_bank)
  );

  always #(TCK/2) clk = ~clk;

  int total = 0, bad = 0;

  // Reference model state
  bit [3:0] m_open;
  int m_act[4], m_pre[4], m_wr[4];
  int g_act, g_ref, g_mrs, g_wr;
  bit ckq;
  int e_code, e_rsn, e_bnk;
  bit e_viol;

  function automatic int inc(int x);
    return (x >= BIG) ? x : x + 1;
  endfunction

  function automatic string rtag(int r);
    case (r)
      1, 2:         return "R3";
      3:            return "R4";
      4:            return "R5";
      5, 6, 7, 8:   return "R6";
      9:            return "R7";
      10, 13:       return "R8";
      11, 12:       return "R9";
      14:           return "R10";
      default:      return "R11";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_open = '0; ckq = 1'b1; e_code = 0; e_rsn = 0; e_bnk = 0; e_viol = 1'b0;
    for (int b = 0; b < 4; b++) begin m_act[b] = BIG; m_pre[b] = BIG; m_wr[b] = BIG; end
    g_act = BIG; g_ref = BIG; g_mrs = BIG; g_wr = BIG;
  endtask

  task automatic model(bit cs, bit rs, bit cs2, bit we, int bk, bit ad10, bit ck, bit clr);
    int code, p, pb, low;
    bit realc, anyo, to, actok, rdok, wrok, refok, mrsok;
    bit pm[4];
    bit h[16];
    int hb[16];
    if (!ck || !ckq) code = 10;
    else if (cs) code = 0;
    else case ({rs, cs2, we})
      3'b111: code = 1;  3'b110: code = 2;  3'b101: code = 3;  3'b100: code = 4;
      3'b011: code = 5;  3'b010: code = ad10 ? 7 : 6;  3'b001: code = 8;
      default: code = 9;
    endcase
    realc = (code >= 2) && (code <= 9);
    anyo  = (m_open != 0);
    to    = m_open[bk];
    actok = (code == 5) && !to;
    rdok  = (code == 3) && to;
    wrok  = (code == 4) && to;
    refok = (code == 8) && !anyo;
    mrsok = (code == 9) && !anyo;
    low = 0;
    for (int b = 3; b >= 0; b--) if (m_open[b]) low = b;
    for (int b = 0; b < 4; b++) pm[b] = m_open[b] && ((code == 7) || (code == 6 && b == bk));
    for (int r = 0; r < 16; r++) begin h[r] = 0; hb[r] = bk; end
    h[1]  = (code == 5) && to;
    h[2]  = (code == 3 || code == 4) && !to;
    h[3]  = (code == 8 || code == 9) && anyo;  hb[3] = low;
    h[4]  = ckq && !ck && anyo;                hb[4] = low;
    h[5]  = (rdok || wrok) && (m_act[bk] < Q_RCD);
    h[6]  = actok && (m_pre[bk] < Q_RP);
    h[8]  = actok && (m_act[bk] < Q_RC);
    h[9]  = actok && (g_act < Q_RRD);
    h[10] = realc && (g_ref < Q_RFC);
    h[12] = rdok && (g_wr < 2);
    h[13] = realc && (g_mrs < 2);
    for (int b = 3; b >= 0; b--) begin
      if (pm[b] && m_act[b] < Q_RAS) begin h[7] = 1; hb[7] = b; end
      if (pm[b] && m_wr[b] < Q_WR)   begin h[11] = 1; hb[11] = b; end
      if (m_open[b] && m_act[b] > Q_RASMAX) begin h[14] = 1; hb[14] = b; end
    end
    p = 0; pb = 0;
    for (int r = 15; r >= 1; r--) if (h[r]) begin p = r; pb = hb[r]; end
    if (p != 0 && (!e_viol || clr)) begin e_viol = 1; e_rsn = p; e_bnk = pb; end
    else if (clr) begin e_viol = 0; e_rsn = 0; e_bnk = 0; end
    for (int b = 0; b < 4; b++) begin
      m_act[b]  = (actok && b == bk) ? 1 : inc(m_act[b]);
      m_pre[b]  = pm[b] ? 1 : inc(m_pre[b]);
      m_wr[b]   = (wrok && b == bk) ? 1 : inc(m_wr[b]);
      m_open[b] = (m_open[b] && !pm[b]) || (actok && b == bk);
    end
    g_act = actok ? 1 : inc(g_act);
    g_ref = refok ? 1 : inc(g_ref);
    g_mrs = mrsok ? 1 : inc(g_mrs);
    g_wr  = wrok  ? 1 : inc(g_wr);
    ckq = ck;
    e_code = code;
  endtask

  // One bus cycle: drive at the falling edge, model at the rising edge,
  // compare at the next falling edge.
  task automatic step(int c, int bk, bit ck, bit clr);
    bit [3:0] pins;
    case (c)
      0: pins = 4'b1111;  1: pins = 4'b0111;  2: pins = 4'b0110;  3: pins = 4'b0101;
      4: pins = 4'b0100;  5: pins = 4'b0011;  6, 7: pins = 4'b0010;  8: pins = 4'b0001;
      default: pins = 4'b0000;
    endcase
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba = 2'(bk); a10 = (c == 7); cke = ck; viol_clr = clr;
    @(posedge clk);
    model(pins[3], pins[2], pins[1], pins[0], bk, (c == 7), ck, clr);
    @(negedge clk);
    chk("R1 cmd_code", int'(cmd_code), e_code);
    chk("R2 bank_open", int'(bank_open), int'(m_open));
    chk({rtag(e_rsn), " viol"}, int'(viol), int'(e_viol));
    chk({rtag(e_rsn), " reason"}, int'(viol_reason), e_rsn);
    chk({rtag(e_rsn), " bank"}, int'(viol_bank), e_bnk);
  endtask

  initial begin
    #(TCK * 190000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset cmd_code", int'(cmd_code), 0);
    chk("R2 reset bank_open", int'(bank_open), 0);
    chk("R11 reset viol", int'(viol), 0);

    // R6: read two cycles after activate breaks tRCD
    step(5, 0, 1, 0); step(1, 0, 1, 0); step(3, 0, 1, 0);
    chk("R6 tRCD reason", int'(viol_reason), 5);
    // R11: clear; R12: read exactly tRCD cycles after activate is fine
    step(1, 0, 1, 1);
    chk("R11 cleared", int'(viol), 0);
    step(5, 1, 1, 0); step(1, 0, 1, 0); step(1, 0, 1, 0); step(3, 1, 1, 0);
    chk("R12 tRCD boundary", int'(viol), 0);
    // R3: activate to open bank, no state change
    step(5, 1, 1, 0);
    chk("R3 reason", int'(viol_reason), 1);
    chk("R3 bank_open unchanged", int'(bank_open), 3);
    // R11: later violation does not replace the first
    step(8, 0, 1, 0);
    chk("R11 sticky reason", int'(viol_reason), 1);
    // R4: refresh with open banks
    step(1, 0, 1, 1); step(8, 0, 1, 0);
    chk("R4 reason", int'(viol_reason), 3);
    chk("R4 bank", int'(viol_bank), 0);
    // R5: clock enable falls with banks open
    step(1, 0, 1, 1); step(1, 0, 0, 0);
    chk("R5 reason", int'(viol_reason), 4);
    step(1, 0, 1, 0); step(1, 0, 1, 1);
    // R2: precharge all closes every bank
    step(7, 0, 1, 0);
    chk("R2 precharge all", int'(bank_open), 0);
    // R7: activates to different banks one cycle apart
    repeat (12) step(1, 0, 1, 0);
    step(1, 0, 1, 1); step(5, 2, 1, 0); step(5, 3, 1, 0);
    chk("R7 reason", int'(viol_reason), 9);
    chk("R7 bank", int'(viol_bank), 3);
    // R10: bank left open past the maximum
    step(7, 0, 1, 0);
    repeat (20) step(1, 0, 1, 0);
    step(1, 0, 1, 1);
    step(5, 0, 1, 0);
    for (int k = 1; k < Q_RASMAX; k++) step(1, 0, 1, 0);
    step(1, 0, 1, 0);
    chk("R10 at limit", int'(viol), 0);
    step(1, 0, 1, 0);
    chk("R10 reason", int'(viol_reason), 14);
    step(7, 0, 1, 1);
    repeat (20) step(1, 0, 1, 1);

    // Random traffic covers R8, R9 and the rest against the model
    for (int n = 0; n < 4000; n++) begin
      int r, c, bk;
      bit ck, clr;
      r  = $urandom_range(0, 15);
      bk = $urandom_range(0, 3);
      ck = 1'b1;
      case (r)
        0, 1:       c = 1;
        2:          c = 0;
        3:          c = 2;
        4, 5:       c = 3;
        6, 7:       c = 4;
        8, 9, 10:   c = 5;
        11:         c = 6;
        12:         c = 7;
        13:         c = 8;
        14:         c = 9;
        default: begin c = 1; ck = 1'b0; end
      endcase
      clr = ($urandom_range(0, 3) == 0);
      step(c, bk, ck, clr);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule